// File: doc/BRIEF.md
# Load/Store Address and Value Watchpoint

This block sits beside a processor's load/store path and watches every access for two programmable conditions. There are two channels. Each one compares the access address against its own programmed address. When the shared range control is set, both channels instead test the address against a window: the lower bound comes from channel 0's address and the upper bound (exclusive) from channel 1's address. Each channel can also require the 32-bit access data to match a programmed compare value. The compare uses a 4-bit byte mask and one of two combining rules: every selected byte equal, or any selected byte equal.

A qualifying hit sets a sticky status flag. A load sets the channel's read flag when its read enable is on, and a store sets its write flag when its write enable is on. Flags stay set until software clears them by writing ones to the clear register. Configuration and clearing share one register write port. Status is presented as a 4-bit vector.

Top module: `dwatch_unit`

Register select codes: 0 = channel 0 address, 1 = channel 1 address, 2 = channel 0 compare value, 3 = channel 1 compare value, 4 = control, 5 = status clear. In the control word, bits [8c+7:8c] belong to channel c:
- bit 0: read enable
- bit 1: write enable
- bits 3:2: value mode
- bits 7:4: byte mask, where mask bit k selects data bits [8k+7:8k]

Bit 16 of the control word is the range control. Status and clear bit 2c is channel c's read flag, and bit 2c+1 is its write flag.

## Requirements
- R1: After reset all four status flags are 0.
- R2: With value compare off, an access whose address equals the channel address (exact mode) sets that channel's read flag for a load (acc_write_i=0) or write flag for a store (acc_write_i=1). The flag is visible on the cycle after the access.
- R3: A load never sets a flag when the channel's read enable is 0. A store never sets a flag when its write enable is 0. A load never sets a write flag, and a store never sets a read flag.
- R4: With range control 1, both channels hit when channel-0 address <= access address < channel-1 address, and neither hits outside that window.
- R5: Value mode 01 hits only when every byte selected by the mask equals the corresponding byte of the compare value, and the address also matches.
- R6: Value mode 10 hits when at least one selected byte equals its compare byte, and the address also matches.
- R7: Value modes 00 and 11 disable the value compare, so the address match alone decides. With value mode 01 or 10 and a mask of 0000, the channel never hits.
- R8: Flags are sticky: an access that does not qualify, and an idle cycle, leave every flag unchanged.
- R9: Writing select 5 clears each flag whose data bit is 1 and leaves the others. If a flag's event occurs in the same cycle as its clear, the flag ends up set.
- R10: The channels are independent: a hit on one channel never changes the other channel's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One-cycle access strobe |
| acc_addr_i | input | AW | Access address |
| acc_data_i | input | 32 | Access data |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| status_o | output | 4 | Sticky flags {ch1 wr, ch1 rd, ch0 wr, ch0 rd} |

## Verification
An event can fall in the same cycle as a software clear of the same flag. The bench provokes this by driving a qualifying load and a clear write of that flag on one edge. It judges the result as correct only if the flag reads 1 afterwards. A clear alone must drop the flag, and a partial clear must drop only the flags named in the written data. Beyond that case, a sweep runs every combination of enables, value mode, byte mask and range control against boundary addresses and partial-match data. Each result is compared with an arithmetic model.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  localparam int NCH    = 2;
  localparam int DW     = 32;
  localparam int NBYTES = DW / 8;
  localparam int NFLAG  = 2 * NCH;

  typedef enum logic [1:0] {
    VM_OFF  = 2'b00,
    VM_ALL  = 2'b01,
    VM_ANY  = 2'b10,
    VM_OFF3 = 2'b11
  } vmode_e;

  typedef struct packed {
    logic [NBYTES-1:0] mask;
    vmode_e            mode;
    logic              wr_en;
    logic              rd_en;
  } chan_cfg_t;

  localparam logic [2:0] SEL_ADDR0 = 3'd0;
  localparam logic [2:0] SEL_ADDR1 = 3'd1;
  localparam logic [2:0] SEL_VAL0  = 3'd2;
  localparam logic [2:0] SEL_VAL1  = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;
  localparam logic [2:0] SEL_CLR   = 3'd5;
  localparam int         RANGE_BIT = 16;
endpackage

// File: rtl/dw_regs.sv
module dw_regs
  import dwatch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [2:0]               sel_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NCH-1:0][AW-1:0]   addr_o,
  output logic [NCH-1:0][DW-1:0]   val_o,
  output chan_cfg_t [NCH-1:0]      cfg_o,
  output logic                     range_o,
  output logic [NFLAG-1:0]         clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      val_o   <= '0;
      cfg_o   <= '0;
      range_o <= 1'b0;
    end else if (we_i) begin
      case (sel_i)
        SEL_ADDR0: addr_o[0] <= wdata_i[AW-1:0];
        SEL_ADDR1: addr_o[1] <= wdata_i[AW-1:0];
        SEL_VAL0:  val_o[0]  <= wdata_i;
        SEL_VAL1:  val_o[1]  <= wdata_i;
        SEL_CTRL: begin
          for (int c = 0; c < NCH; c++) cfg_o[c] <= wdata_i[8*c +: 8];
          range_o <= wdata_i[RANGE_BIT];
        end
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && sel_i == SEL_CLR) ? wdata_i[NFLAG-1:0] : '0;
endmodule

// File: rtl/dw_addr_cmp.sv
module dw_addr_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] own_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic          range_i,
  output logic          hit_o
);
  always_comb begin
    if (range_i) hit_o = (addr_i >= lo_i) && (addr_i < hi_i);
    else         hit_o = (addr_i == own_i);
  end
endmodule

// File: rtl/dw_val_cmp.sv
module dw_val_cmp
  import dwatch_pkg::*;
(
  input  logic [DW-1:0]     data_i,
  input  logic [DW-1:0]     cmp_i,
  input  vmode_e            mode_i,
  input  logic [NBYTES-1:0] mask_i,
  output logic              ok_o
);
  logic [NBYTES-1:0] eq;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign eq[b] = (data_i[8*b +: 8] == cmp_i[8*b +: 8]);
  end

  // ok_o means the value condition does not block the hit
  always_comb begin
    case (mode_i)
      VM_ALL:  ok_o = (mask_i != '0) && ((eq & mask_i) == mask_i);
      VM_ANY:  ok_o = |(eq & mask_i);
      default: ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dw_flags.sv
module dw_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] set_i,
  input  logic [1:0] clr_i,
  output logic [1:0] flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= set_i | (flag_o & ~clr_i);
  end

  for (genvar i = 0; i < 2; i++) begin : g_chk
    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
    assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
  end
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [31:0]   acc_data_i,
  input  logic          acc_write_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [3:0]    status_o
);
  logic [NCH-1:0][AW-1:0] addr_q;
  logic [NCH-1:0][DW-1:0] val_q;
  chan_cfg_t [NCH-1:0]    cfg_q;
  logic                   range_q;
  logic [NFLAG-1:0]       clr;

  dw_regs #(.AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .addr_o  (addr_q),
    .val_o   (val_q),
    .cfg_o   (cfg_q),
    .range_o (range_q),
    .clr_o   (clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       a_hit, v_ok, hit;
    logic [1:0] set;

    dw_addr_cmp #(.AW(AW)) u_acmp (
      .addr_i  (acc_addr_i),
      .own_i   (addr_q[c]),
      .lo_i    (addr_q[0]),
      .hi_i    (addr_q[1]),
      .range_i (range_q),
      .hit_o   (a_hit)
    );

    dw_val_cmp u_vcmp (
      .data_i (acc_data_i),
      .cmp_i  (val_q[c]),
      .mode_i (cfg_q[c].mode),
      .mask_i (cfg_q[c].mask),
      .ok_o   (v_ok)
    );

    assign hit    = acc_valid_i && a_hit && v_ok;
    assign set[0] = hit && !acc_write_i && cfg_q[c].rd_en;
    assign set[1] = hit &&  acc_write_i && cfg_q[c].wr_en;

    dw_flags u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set),
      .clr_i  (clr[2*c +: 2]),
      .flag_o (status_o[2*c +: 2])
    );

    assert_rd_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[2*c]) |-> $past(acc_valid_i && !acc_write_i && cfg_q[c].rd_en));
    assert_wr_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[2*c+1]) |-> $past(acc_valid_i && acc_write_i && cfg_q[c].wr_en));
    assert_zero_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[2*c +: 2] != 2'b00) |->
        $past(!(cfg_q[c].mode inside {VM_ALL, VM_ANY}) || cfg_q[c].mask != '0));
  end

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !(cfg_we_i && cfg_sel_i == SEL_CLR)) |=> $stable(status_o));
endmodule

// File: tb/dwatch_unit_bench.sv
`timescale 1ns/1ps
module dwatch_unit_bench;
  localparam logic [31:0] A0 = 32'h100, A1 = 32'h140;
  localparam logic [31:0] V0 = 32'h11223344, V1 = 32'h55667788;

  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0, acc_write = 0, cfg_we = 0;
  logic [31:0] acc_addr = 0, acc_data = 0, cfg_wdata = 0;
  logic [2:0]  cfg_sel = 0;
  logic [3:0]  status;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dwatch_unit u_dwatch_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_data_i(acc_data),
    .acc_write_i(acc_write), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .status_o(status)
  );

  logic [31:0] ctrl;

  function automatic logic [1:0] chan_model(int c, logic [31:0] a, logic [31:0] d, logic w);
    logic [7:0] f = ctrl[8*c +: 8];
    logic [31:0] own = (c == 0) ? A0 : A1;
    logic [31:0] v = (c == 0) ? V0 : V1;
    logic [3:0] eq, m;
    logic ah, vh, h;
    ah = ctrl[16] ? (a >= A0 && a < A1) : (a == own);
    for (int b = 0; b < 4; b++) eq[b] = d[8*b +: 8] == v[8*b +: 8];
    m = f[7:4];
    if (f[3:2] == 2'b01)      vh = (m != 0) && ((eq & m) == m);
    else if (f[3:2] == 2'b10) vh = (eq & m) != 0;
    else                      vh = 1'b1;
    h = ah && vh;
    return {h && w && f[1], h && !w && f[0]};
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    total++;
    if (status !== exp) begin
      bad++;
      $display("FAIL %s status got %b exp %b", tag, status, exp);
    end
  endtask

  // drive one cycle of access and/or register write, return at next negedge
  task automatic step(logic v, logic [31:0] a, logic [31:0] d, logic w,
                      logic we, logic [2:0] sel, logic [31:0] wd);
    acc_valid = v; acc_addr = a; acc_data = d; acc_write = w;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    acc_valid = 0; cfg_we = 0;
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] wd);
    if (sel == 3'd4) ctrl = wd;
    step(0, 0, 0, 0, 1, sel, wd);
  endtask

  task automatic acc(logic [31:0] a, logic [31:0] d, logic w);
    step(1, a, d, w, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [4];
    logic [31:0] datas [4];
    logic [3:0] e;
    addrs = '{A0, A1 - 1, A1, A0 - 1};
    datas = '{V0, V1, 32'h11AA33BB, 32'h55000088};
    ctrl = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", 4'b0000);

    wr(0, A0); wr(1, A1); wr(2, V0); wr(3, V1);

    // R4 range window boundaries
    wr(4, 32'h0001_0303);
    acc(A1 - 1, 0, 0); check("R4 upper-1", 4'b0101); wr(5, 4'hF);
    acc(A1, 0, 0);     check("R4 upper excl", 4'b0000);
    acc(A0, 0, 0);     check("R4 lower incl", 4'b0101); wr(5, 4'hF);
    acc(A0 - 1, 0, 1); check("R4 below", 4'b0000);

    // R2 exact, R3 gating, R8 sticky
    wr(4, 32'h0000_0001);
    acc(A0, 0, 0);     check("R2 exact load", 4'b0001);
    acc(32'h200, 0, 0); check("R8 miss keeps", 4'b0001);
    acc(A0, 0, 1);     check("R3 store wr_en=0", 4'b0001);
    @(negedge clk);    check("R8 idle keeps", 4'b0001);

    // R9 clear vs event
    step(1, A0, 0, 0, 1, 3'd5, 32'hF); check("R9 event beats clear", 4'b0001);
    wr(5, 32'h1);      check("R9 clear", 4'b0000);
    wr(4, 32'h0000_0201);
    acc(A0, 0, 0); acc(A1, 0, 1); check("R2 both chans", 4'b1001);
    wr(5, 32'h1);      check("R9 partial clear", 4'b1000);
    acc(A1, 0, 0);     check("R10 ch1 rd_en=0", 4'b1000);
    acc(A0, 0, 1);     check("R10 ch0 store gated", 4'b1000);
    wr(5, 32'hF);

    // sweep: enables, mode, mask, range; R5 R6 R7 R3 R10
    for (int r = 0; r < 2; r++)
      for (int rw = 0; rw < 4; rw++)
        for (int md = 0; md < 4; md++)
          for (int mk = 0; mk < 16; mk++) begin
            logic [7:0] f0, f1;
            f0 = {mk[3:0], md[1:0], rw[1:0]};
            f1 = {~mk[3:0], 2'(md + 1), ~rw[1:0]};
            wr(4, {15'd0, r[0], f1, f0});
            for (int ai = 0; ai < 4; ai++)
              for (int di = 0; di < 4; di++)
                for (int w = 0; w < 2; w++) begin
                  acc(addrs[ai], datas[di], w[0]);
                  e = {chan_model(1, addrs[ai], datas[di], w[0]),
                       chan_model(0, addrs[ai], datas[di], w[0])};
                  check("R5/R6/R7 sweep", e);
                  wr(5, 32'hF);
                end
          end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule